// File: doc/BRIEF.md
# Byte-Register PWM Generator with Auto-Off Timer

This block produces one pulse-width modulated output whose shape is set through a narrow write-only register port: an 8-bit address, an 8-bit data byte and a write strobe. The period, the high time and an auto-off count are 16-bit values. Each one is written as two bytes. The upper byte waits in a staging register. The whole value goes live on the write of its lower byte. A separate register holds the run/stop bit.

The period counter does not step on every clock. It steps once per timebase tick, which an internal clock divider makes from the system clock (one tick every `TICK_DIV` clocks, 125 ns at the default setting). The output is high during the first duty ticks of each period and low for the rest. Polarity is fixed. The auto-off count lets the output shut itself down after a chosen number of full periods. Loading all ones turns that count off.

Because each value goes live on its own low-byte write, software that changes both period and duty sees a short window in which the old duty meets the new period. If that old duty is not below the new period, the output reads fully high during the window.

Top module: `bytereg_pwm`

## Requirements
- R1: After reset the output is low, the run bit is 0, period and duty are 0, and the auto-off count is 0xFFFF.
- R2: While running with 0 < duty < period, each cycle has the output high for exactly duty ticks and then low for period minus duty ticks, with one tick every TICK_DIV clocks.
- R3: Address map: 0xA5/0xA4 are the period high/low bytes, 0xA7/0xA6 the duty high/low bytes, and 0xA1/0xA2 the auto-off high/low bytes. A high-byte write only stages its byte. The 16-bit value {staged byte, written byte} goes live on the low-byte write.
- R4: While running with a nonzero period and duty greater than or equal to period, the output stays high without a break.
- R5: Bit 0 of a write to address 0xA3 sets the run bit (1 runs, 0 stops). While the run bit is 0 the output is low and the period counter is held at 0.
- R6: A live period of 0 or a live duty of 0 keeps the output low.
- R7: When the auto-off count is not 0xFFFF, each completed period while running reduces it by one. The period that takes it from 1 to 0 clears the run bit. A count of 0 clears the run bit at the end of the next completed period.
- R8: An auto-off count of 0xFFFF never changes and never clears the run bit.
- R9: A period or duty commit restarts the period counter at 0 on the next tick after the commit.
- R10: Writes to any address outside 0xA1 to 0xA7 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one byte per cycle it is high |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register data byte |
| pwm_out | output | 1 | Pulse-width modulated output, high-active |

## Verification
The assertions check these rules on every cycle:
- A stopped block, a zero period or a zero duty gives a low output.
- A duty not below the period gives a constant high.
- The live period and duty move only on their low-byte writes.
- An all-ones auto-off count stays put.

Some behaviour only the bench scenarios can show:
- The exact high and low run lengths in clocks.
- The one-tick restart after a commit.
- The number of pulses before auto-off stops the output.
- The effect of a staged high byte alone.
- That writes to unmapped addresses change nothing.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
  localparam int BYTE_W = 8;
  localparam int VAL_W  = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] ADR_AOFF_HI = 8'hA1;
  localparam logic [BYTE_W-1:0] ADR_AOFF_LO = 8'hA2;
  localparam logic [BYTE_W-1:0] ADR_RUN     = 8'hA3;
  localparam logic [BYTE_W-1:0] ADR_PER_LO  = 8'hA4;
  localparam logic [BYTE_W-1:0] ADR_PER_HI  = 8'hA5;
  localparam logic [BYTE_W-1:0] ADR_DUTY_LO = 8'hA6;
  localparam logic [BYTE_W-1:0] ADR_DUTY_HI = 8'hA7;

  localparam logic [VAL_W-1:0] AOFF_NEVER = '1;
endpackage

// File: rtl/bpwm_tick.sv
module bpwm_tick #(
  parameter int DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q, div_d;

  assign tick = (div_q == LAST);

  always_comb begin
    div_d = tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/bpwm_regs.sv
module bpwm_regs
  import bpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              expire,
  output logic              run,
  output logic [VAL_W-1:0]  period,
  output logic [VAL_W-1:0]  duty,
  output logic              restart,
  output logic              aoff_load,
  output logic [VAL_W-1:0]  aoff_value
);
  localparam int NSPLIT = 2;

  logic [VAL_W-1:0] live_q [NSPLIT];
  logic [NSPLIT-1:0] commit;

  genvar g;
  generate
    for (g = 0; g < NSPLIT; g++) begin : g_split
      localparam logic [BYTE_W-1:0] LO = (g == 0) ? ADR_PER_LO : ADR_DUTY_LO;
      localparam logic [BYTE_W-1:0] HI = (g == 0) ? ADR_PER_HI : ADR_DUTY_HI;
      logic [BYTE_W-1:0] stage_q, stage_d;
      logic [VAL_W-1:0]  live_d;
      logic              hi_wr;

      assign hi_wr     = wr_en && (wr_addr == HI);
      assign commit[g] = wr_en && (wr_addr == LO);

      always_comb begin
        stage_d = hi_wr ? wr_data : stage_q;
        live_d  = commit[g] ? {stage_q, wr_data} : live_q[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q   <= '0;
          live_q[g] <= '0;
        end else begin
          stage_q   <= stage_d;
          live_q[g] <= live_d;
        end
      end
    end
  endgenerate

  assign period  = live_q[0];
  assign duty    = live_q[1];
  assign restart = |commit;

  logic [BYTE_W-1:0] aoff_hi_q, aoff_hi_d;
  logic run_q, run_d;
  logic run_wr;

  assign aoff_load  = wr_en && (wr_addr == ADR_AOFF_LO);
  assign aoff_value = {aoff_hi_q, wr_data};
  assign run_wr     = wr_en && (wr_addr == ADR_RUN);
  assign run        = run_q;

  always_comb begin
    aoff_hi_d = (wr_en && (wr_addr == ADR_AOFF_HI)) ? wr_data : aoff_hi_q;
    if (run_wr)      run_d = wr_data[0];
    else if (expire) run_d = 1'b0;
    else             run_d = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aoff_hi_q <= '0;
      run_q     <= 1'b0;
    end else begin
      aoff_hi_q <= aoff_hi_d;
      run_q     <= run_d;
    end
  end
endmodule

// File: rtl/bpwm_core.sv
module bpwm_core
  import bpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [VAL_W-1:0] period,
  input  logic [VAL_W-1:0] duty,
  input  logic             restart,
  input  logic             aoff_load,
  input  logic [VAL_W-1:0] aoff_value,
  output logic             pwm_out,
  output logic             expire
);
  logic [VAL_W-1:0] cnt_q, cnt_d;
  logic [VAL_W-1:0] aoff_q, aoff_d;
  logic pend_q, pend_d;
  logic wrap, per_zero, aoff_active;

  assign per_zero    = (period == '0);
  assign wrap        = run && tick && !pend_q && !per_zero && (cnt_q >= period - 1'b1);
  assign aoff_active = (aoff_q != AOFF_NEVER);
  assign expire      = wrap && aoff_active && (aoff_q <= VAL_W'(1));

  always_comb begin
    pend_d = restart || (pend_q && !tick);

    if (!run)                      cnt_d = '0;
    else if (!tick)                cnt_d = cnt_q;
    else if (pend_q || per_zero)   cnt_d = '0;
    else if (wrap)                 cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;

    if (aoff_load)                 aoff_d = aoff_value;
    else if (wrap && aoff_active)  aoff_d = (aoff_q == '0) ? '0 : aoff_q - 1'b1;
    else                           aoff_d = aoff_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      aoff_q <= AOFF_NEVER;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      aoff_q <= aoff_d;
      pend_q <= pend_d;
    end
  end

  assign pwm_out = run && !per_zero && ((duty >= period) || (cnt_q < duty));
endmodule

// File: rtl/bytereg_pwm.sv
module bytereg_pwm
  import bpwm_pkg::*;
#(
  parameter int TICK_DIV = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              pwm_out
);
  logic [1:0] rsync_q;
  logic rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  logic tick, run, restart, aoff_load, expire;
  logic [VAL_W-1:0] period, duty, aoff_value;

  bpwm_tick #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n_s),
    .tick  (tick)
  );

  bpwm_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .expire     (expire),
    .run        (run),
    .period     (period),
    .duty       (duty),
    .restart    (restart),
    .aoff_load  (aoff_load),
    .aoff_value (aoff_value)
  );

  bpwm_core u_core (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .tick       (tick),
    .run        (run),
    .period     (period),
    .duty       (duty),
    .restart    (restart),
    .aoff_load  (aoff_load),
    .aoff_value (aoff_value),
    .pwm_out    (pwm_out),
    .expire     (expire)
  );
endmodule

// File: rtl/bytereg_pwm_chk.sv
module bytereg_pwm_chk
  import bpwm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [BYTE_W-1:0] wr_addr,
  input logic              pwm_out,
  input logic              run,
  input logic [VAL_W-1:0]  period,
  input logic [VAL_W-1:0]  duty,
  input logic [VAL_W-1:0]  aoff
);
  // R5
  stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !pwm_out);

  // R6
  zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((period == '0) || (duty == '0)) |-> !pwm_out);

  // R4
  full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (period != '0) && (duty >= period)) |-> pwm_out);

  // R3
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == ADR_PER_LO)) |=> $stable(period));

  // R3
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == ADR_DUTY_LO)) |=> $stable(duty));

  // R8
  aoff_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((aoff == AOFF_NEVER) && !(wr_en && (wr_addr == ADR_AOFF_LO))) |=> (aoff == AOFF_NEVER));
endmodule

bind bytereg_pwm bytereg_pwm_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .pwm_out (pwm_out),
  .run     (run),
  .period  (period),
  .duty    (duty),
  .aoff    (u_core.aoff_q)
);

// File: tb/bytereg_pwm_test.sv
`timescale 1ns/1ps
module bytereg_pwm_test;
  localparam int DIV = 25;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic pwm_out;

  always #2.5 clk = ~clk;

  bytereg_pwm #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  int checks = 0;
  int errors = 0;

  typedef struct { int hi; int lo; string req; } pair_t;
  pair_t sb_q[$];
  logic mon_on = 1'b0;

  function automatic void check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  // monitor: measures high/low runs in clocks, compares with scoreboard
  int m_phase = 0, m_hi = 0, m_lo = 0;
  logic m_prev = 1'b0;
  always @(negedge clk) begin
    if (!mon_on) m_phase = 0;
    else begin
      case (m_phase)
        0: if (!m_prev && pwm_out) begin m_phase = 1; m_hi = 1; end
        1: if (pwm_out) m_hi++; else begin m_phase = 2; m_lo = 1; end
        default: if (!pwm_out) m_lo++;
          else begin
            if (sb_q.size() > 0) begin
              pair_t e;
              e = sb_q.pop_front();
              check(m_hi == e.hi, {e.req, " high clocks"}, m_hi, e.hi);
              check(m_lo == e.lo, {e.req, " low clocks"}, m_lo, e.lo);
            end
            m_phase = 1; m_hi = 1;
          end
      endcase
    end
    m_prev = pwm_out;
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic set16(input logic [7:0] hi_a, input logic [7:0] lo_a, input logic [15:0] v);
    wr(hi_a, v[15:8]);
    wr(lo_a, v[7:0]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pairs(input int hi_t, input int lo_t, input int n, input string req);
    int t;
    idle(2 * (hi_t + lo_t) * DIV + 2 * DIV);
    for (int i = 0; i < n; i++) begin
      pair_t e;
      e.hi = hi_t * DIV; e.lo = lo_t * DIV; e.req = req;
      sb_q.push_back(e);
    end
    mon_on = 1'b1;
    t = 0;
    while (sb_q.size() > 0 && t < (n + 2) * (hi_t + lo_t) * DIV + 4 * DIV) begin
      @(negedge clk); t++;
    end
    check(sb_q.size() == 0, {req, " pulses seen"}, n - sb_q.size(), n);
    sb_q.delete();
    mon_on = 1'b0;
  endtask

  task automatic check_level(input logic v, input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out !== v) bad++;
    end
    check(bad == 0, {req, " level mismatches"}, bad, 0);
  endtask

  task automatic count_rises(input int n, output int cnt);
    logic p = 1'b0;
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out && !p) cnt++;
      p = pwm_out;
      @(negedge clk);
    end
  endtask

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rises;
    int low_n;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state, output low; reset period 0 keeps output low when run
    check_level(1'b0, 100, "R1");
    wr(8'hA3, 8'h01);
    check_level(1'b0, 200, "R1 R6 reset period");
    wr(8'hA3, 8'h00);

    // R2: basic pulse shapes
    set16(8'hA5, 8'hA4, 16'd8);
    set16(8'hA7, 8'hA6, 16'd3);
    wr(8'hA3, 8'h01);
    expect_pairs(3, 5, 3, "R2 8/3");
    set16(8'hA5, 8'hA4, 16'h0100);
    set16(8'hA7, 8'hA6, 16'h0040);
    expect_pairs(64, 192, 2, "R2 R3 256/64");
    set16(8'hA5, 8'hA4, 16'd10);
    set16(8'hA7, 8'hA6, 16'd7);
    expect_pairs(7, 3, 2, "R2 10/7");

    // R3: high byte alone only stages
    wr(8'hA7, 8'h01);
    expect_pairs(7, 3, 2, "R3 staged only");
    wr(8'hA6, 8'h00);
    idle(3 * DIV);
    check_level(1'b1, 600, "R4 R3 duty 256 >= period 10");

    // R6: zero duty
    set16(8'hA7, 8'hA6, 16'd0);
    idle(2);
    check_level(1'b0, 400, "R6 zero duty");

    // R4: mixed state between period and duty updates
    set16(8'hA5, 8'hA4, 16'd8);
    set16(8'hA7, 8'hA6, 16'd6);
    expect_pairs(6, 2, 1, "R2 8/6");
    set16(8'hA5, 8'hA4, 16'd4);
    idle(2 * DIV);
    check_level(1'b1, 300, "R4 old duty vs new period");
    set16(8'hA7, 8'hA6, 16'd1);
    expect_pairs(1, 3, 3, "R2 4/1");

    // R9: commit restarts counter on the next tick
    set16(8'hA5, 8'hA4, 16'd8);
    set16(8'hA7, 8'hA6, 16'd4);
    idle(20 * DIV);
    while (pwm_out) @(negedge clk);
    while (!pwm_out) @(negedge clk);
    while (pwm_out) @(negedge clk);
    low_n = 1;
    wr(8'hA6, 8'd4);
    while (!pwm_out && low_n < 10 * DIV) begin low_n++; @(negedge clk); end
    check(low_n == DIV, "R9 low run after commit", low_n, DIV);

    // R5: stop forces low
    wr(8'hA3, 8'h00);
    check_level(1'b0, 400, "R5 stopped");
    wr(8'hA3, 8'h01);
    expect_pairs(4, 4, 2, "R5 restarted");

    // R10: unmapped writes ignored
    wr(8'hA0, 8'h00);
    wr(8'hA8, 8'h00);
    wr(8'h23, 8'h00);
    wr(8'h24, 8'h01);
    wr(8'hB6, 8'h00);
    expect_pairs(4, 4, 2, "R10 unmapped");

    // R7: auto-off after three periods
    wr(8'hA3, 8'h00);
    set16(8'hA5, 8'hA4, 16'd4);
    set16(8'hA7, 8'hA6, 16'd2);
    set16(8'hA1, 8'hA2, 16'd3);
    idle(2);
    wr(8'hA3, 8'h01);
    count_rises(1500, rises);
    check(rises == 3, "R7 pulses before auto-off", rises, 3);
    check_level(1'b0, 300, "R7 stays off");
    // R7: count now 0 gives one more period
    wr(8'hA3, 8'h01);
    count_rises(1000, rises);
    check(rises == 1, "R7 zero count one period", rises, 1);

    // R8: all ones disables auto-off
    set16(8'hA1, 8'hA2, 16'hFFFF);
    idle(2);
    wr(8'hA3, 8'h01);
    count_rises(3000, rises);
    check(rises >= 29, "R8 auto-off disabled", rises, 30);
    expect_pairs(2, 2, 2, "R8 still running");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule